// File: doc/BRIEF.md
# Carry-Skip Adder with Incrementing Stages

This block adds two unsigned operands and a carry input in a single combinational pass. The operand width is split into stages. Each stage works out its own slice sum and generate flag with an internal ripple chain whose carry input is tied to zero. It also forms a group-propagate flag, which is set when every bit pair in the slice differs. An incrementer then folds the incoming carry into the slice sum. The carry passed between stages goes only through a compound-gate skip circuit, so the critical path crosses one gate per stage and no ripple chain lies on it.

The skip gates alternate between an AND-OR-Invert form and an OR-AND-Invert form. The inter-stage carry therefore flips polarity at every boundary. Even-indexed stages receive a true carry and pass on its complement. Odd-indexed stages receive the complement and pass on the true value. The partition is chosen by parameter. In fixed mode every stage has one width and the last stage takes the remainder. In variable mode a list of per-stage widths is given.

Top module: `cska_adder`

## Requirements
- R1: For every operand pair and carry input, the concatenation {carryOut, sum} equals addendA + addendB + carryIn as an unsigned number of WIDTH+1 bits.
- R2: When addendB is the bitwise complement of addendA (all positions propagate), carryOut equals carryIn. In that case sum is all ones for carryIn = 0 and all zeros for carryIn = 1.
- R3: With both operands zero, sum equals carryIn zero-extended and carryOut is 0.
- R4: A carry injected at bit 0 travels across every stage boundary. With addendA all ones, addendB zero and carryIn = 1, the result is sum = 0 and carryOut = 1.
- R5: carryOut is in true polarity whether the partition has an odd or an even number of stages.
- R6: In fixed mode (USE_VAR = 0) the stages are FIXED_W bits wide, starting from bit 0, and the last stage holds the remaining WIDTH mod FIXED_W bits when that value is nonzero. The sum stays exact in that case.
- R7: In variable mode (USE_VAR = 1), stage i is VAR_SIZES[8*i +: 8] bits wide, starting from bit 0. The list ends at the first zero field, and the widths must add up to WIDTH.
- R8: The block holds no state. sum and carryOut depend only on the present inputs, and no clock is involved.
- R9: When carryOut is 1 and carryIn is 0, the wrapped sum is strictly less than addendA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addendA | input | WIDTH | first operand |
| addendB | input | WIDTH | second operand |
| carryIn | input | 1 | carry into bit 0 |
| sum | output | WIDTH | low WIDTH bits of the result |
| carryOut | output | 1 | carry out of the top bit, true polarity |

## Verification
Every result is due in the same cycle as its stimulus, because the block is purely combinational and has no register on any path. The bench drives a new input set and waits a short settling delay, with no clock edge in between. It then samples sum and carryOut before it changes anything else, so each check sees exactly the result of the operands it just applied. Four instances are compared against a behavioural sum: a fixed partition with an odd stage count, a fixed partition with a remainder stage, and two variable partitions.

// File: rtl/cska_pkg.sv
package cska_pkg;
  localparam int MAX_STAGES = 32;
  localparam int FIELD_W = 8;
  typedef logic [MAX_STAGES*FIELD_W-1:0] sizeListT;

  // number of stages in the chosen partition
  function automatic int stageCount(int width, bit useVar, int fixedW, sizeListT sizes);
    int n;
    bit done;
    n = 0;
    done = 1'b0;
    if (!useVar) return (width + fixedW - 1) / fixedW;
    for (int i = 0; i < MAX_STAGES; i++) begin
      if (!done) begin
        if (sizes[i*FIELD_W +: FIELD_W] == '0) done = 1'b1;
        else n++;
      end
    end
    return n;
  endfunction

  // lowest bit position covered by stage idx
  function automatic int stageLsb(int idx, bit useVar, int fixedW, sizeListT sizes);
    int lsb;
    lsb = 0;
    if (!useVar) return idx * fixedW;
    for (int i = 0; i < MAX_STAGES; i++) begin
      if (i < idx) lsb += int'(sizes[i*FIELD_W +: FIELD_W]);
    end
    return lsb;
  endfunction

  // width of stage idx; the last fixed stage takes the remainder
  function automatic int stageWidth(int idx, int width, bit useVar, int fixedW, sizeListT sizes);
    int rem;
    if (useVar) return int'(sizes[idx*FIELD_W +: FIELD_W]);
    rem = width - idx * fixedW;
    return (rem < fixedW) ? rem : fixedW;
  endfunction
endpackage

// File: rtl/cska_slice.sv
// Carry-independent part of a stage: ripple sum with zero carry-in,
// generate flag and group-propagate flag.
module cska_slice #(
  parameter int W = 4
) (
  input  logic [W-1:0] sliceA,
  input  logic [W-1:0] sliceB,
  output logic [W-1:0] partialSum,
  output logic         groupGen,
  output logic         groupProp
);
  logic [W-1:0] halfSum;

  always_comb begin
    logic rippleC;
    rippleC = 1'b0;
    halfSum = sliceA ^ sliceB;
    for (int i = 0; i < W; i++) begin
      partialSum[i] = halfSum[i] ^ rippleC;
      rippleC = (sliceA[i] & sliceB[i]) | (halfSum[i] & rippleC);
    end
    groupGen = rippleC;
  end

  assign groupProp = &halfSum;
endmodule

// File: rtl/cska_incr.sv
// Adds a single carry into the precomputed slice sum.
module cska_incr #(
  parameter int W = 4
) (
  input  logic [W-1:0] partialSum,
  input  logic         trueCarry,
  output logic [W-1:0] stageSum
);
  always_comb begin
    logic runC;
    runC = trueCarry;
    for (int i = 0; i < W; i++) begin
      stageSum[i] = partialSum[i] ^ runC;
      runC = runC & partialSum[i];
    end
  end
endmodule

// File: rtl/cska_skip.sv
// Compound-gate skip: AOI when the incoming carry is true (output inverted),
// OAI when the incoming carry is inverted (output true).
module cska_skip #(
  parameter bit INVERTED_IN = 1'b0
) (
  input  logic groupGen,
  input  logic groupProp,
  input  logic linkIn,
  output logic linkOut
);
  if (!INVERTED_IN) begin : gAoi
    assign linkOut = ~(groupGen | (groupProp & linkIn));
  end else begin : gOai
    assign linkOut = ~((~groupProp | linkIn) & ~groupGen);
  end
endmodule

// File: rtl/cska_stage.sv
module cska_stage #(
  parameter int W = 4,
  parameter bit INVERTED_IN = 1'b0
) (
  input  logic [W-1:0] sliceA,
  input  logic [W-1:0] sliceB,
  input  logic         linkIn,
  output logic [W-1:0] stageSum,
  output logic         linkOut
);
  logic [W-1:0] partialSum;
  logic groupGen;
  logic groupProp;
  logic trueCarry;

  cska_slice #(.W(W)) uSlice (
    .sliceA(sliceA), .sliceB(sliceB), .partialSum(partialSum),
    .groupGen(groupGen), .groupProp(groupProp)
  );

  assign trueCarry = INVERTED_IN ? ~linkIn : linkIn;

  cska_incr #(.W(W)) uIncr (
    .partialSum(partialSum), .trueCarry(trueCarry), .stageSum(stageSum)
  );

  cska_skip #(.INVERTED_IN(INVERTED_IN)) uSkip (
    .groupGen(groupGen), .groupProp(groupProp), .linkIn(linkIn), .linkOut(linkOut)
  );
endmodule

// File: rtl/cska_adder.sv
module cska_adder #(
  parameter int WIDTH = 32,
  parameter bit USE_VAR = 1'b1,
  parameter int FIXED_W = 4,
  parameter cska_pkg::sizeListT VAR_SIZES = 256'h0304050605040302
) (
  input  logic [WIDTH-1:0] addendA,
  input  logic [WIDTH-1:0] addendB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sum,
  output logic             carryOut
);
  localparam int NUM_STAGES = cska_pkg::stageCount(WIDTH, USE_VAR, FIXED_W, VAR_SIZES);

  // link[k] enters stage k; polarity is true for even k, inverted for odd k
  logic [NUM_STAGES:0] link;
  assign link[0] = carryIn;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : gStage
    localparam int LSB = cska_pkg::stageLsb(k, USE_VAR, FIXED_W, VAR_SIZES);
    localparam int SW = cska_pkg::stageWidth(k, WIDTH, USE_VAR, FIXED_W, VAR_SIZES);
    cska_stage #(.W(SW), .INVERTED_IN((k % 2) == 1)) uStage (
      .sliceA(addendA[LSB +: SW]),
      .sliceB(addendB[LSB +: SW]),
      .linkIn(link[k]),
      .stageSum(sum[LSB +: SW]),
      .linkOut(link[k+1])
    );
  end

  if ((NUM_STAGES % 2) == 1) begin : gFixPol
    assign carryOut = ~link[NUM_STAGES];
  end else begin : gKeepPol
    assign carryOut = link[NUM_STAGES];
  end
endmodule

// File: rtl/cska_adder_chk.sv
module cska_adder_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] addendA,
  input logic [WIDTH-1:0] addendB,
  input logic             carryIn,
  input logic [WIDTH-1:0] sum,
  input logic             carryOut
);
  logic [WIDTH:0] refSum;
  logic known;

  always_comb begin
    refSum = {1'b0, addendA} + {1'b0, addendB} + {{WIDTH{1'b0}}, carryIn};
    known = !$isunknown({addendA, addendB, carryIn});
    if (known) begin
      // R1 R5 R8
      exact_sum_chk: assert ({carryOut, sum} == refSum);
      // R2
      all_prop_chk: assert (!(addendB == ~addendA) || (carryOut == carryIn));
      // R3
      zero_op_chk: assert (!(addendA == '0 && addendB == '0) ||
                           (sum == {{(WIDTH-1){1'b0}}, carryIn} && !carryOut));
      // R4
      full_ripple_chk: assert (!(addendA == '1 && addendB == '0 && carryIn) ||
                               (sum == '0 && carryOut));
      // R9
      wrap_chk: assert (!(carryOut && !carryIn) || (sum < addendA));
    end
  end
endmodule

bind cska_adder cska_adder_chk #(.WIDTH(WIDTH)) uChk (
  .addendA(addendA), .addendB(addendB), .carryIn(carryIn),
  .sum(sum), .carryOut(carryOut)
);

// File: tb/tb_cska_adder.sv
`timescale 1ns/1ps
module tb_cska_adder;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 1'b0;

  // default instance: 32-bit variable partition 2,3,4,5,6,5,4,3 (8 stages)
  logic [31:0] a32, b32, s32; logic c32, co32;
  cska_adder dut (.addendA(a32), .addendB(b32), .carryIn(c32), .sum(s32), .carryOut(co32));

  // 8-bit fixed width 3: stages 3,3,2 (odd count, remainder)
  logic [7:0] a8, b8, s8; logic c8, co8;
  cska_adder #(.WIDTH(8), .USE_VAR(1'b0), .FIXED_W(3)) dut8 (
    .addendA(a8), .addendB(b8), .carryIn(c8), .sum(s8), .carryOut(co8));

  // 16-bit fixed width 5: stages 5,5,5,1
  logic [15:0] a16, b16, s16; logic c16, co16;
  cska_adder #(.WIDTH(16), .USE_VAR(1'b0), .FIXED_W(5)) dut16 (
    .addendA(a16), .addendB(b16), .carryIn(c16), .sum(s16), .carryOut(co16));

  // 64-bit variable partition 4,5,6,7,8,9,8,7,6,4
  logic [63:0] a64, b64, s64; logic c64, co64;
  cska_adder #(.WIDTH(64), .USE_VAR(1'b1), .VAR_SIZES(256'h04060708090807060504)) dut64 (
    .addendA(a64), .addendB(b64), .carryIn(c64), .sum(s64), .carryOut(co64));

  typedef struct packed {
    logic [31:0] a; logic [31:0] b; logic ci; logic [31:0] s; logic co;
  } vecT;

  localparam vecT VECS [10] = '{
    '{32'h0, 32'h0, 1'b0, 32'h0, 1'b0},                        // R3
    '{32'h0, 32'h0, 1'b1, 32'h1, 1'b0},                        // R3
    '{32'hFFFFFFFF, 32'h0, 1'b1, 32'h0, 1'b1},                 // R4
    '{32'hFFFFFFFF, 32'h1, 1'b0, 32'h0, 1'b1},                 // R1 R9
    '{32'h12345678, 32'h87654321, 1'b0, 32'h99999999, 1'b0},   // R1
    '{32'hAAAAAAAA, 32'h55555555, 1'b0, 32'hFFFFFFFF, 1'b0},   // R2
    '{32'hAAAAAAAA, 32'h55555555, 1'b1, 32'h0, 1'b1},          // R2
    '{32'h80000000, 32'h80000000, 1'b0, 32'h0, 1'b1},          // R1 R9
    '{32'h7FFFFFFF, 32'h1, 1'b0, 32'h80000000, 1'b0},          // R1
    '{32'hF0F0F0F0, 32'h0F0F0F0F, 1'b1, 32'h0, 1'b1}           // R2
  };

  task automatic checkRes(input string req, input logic [64:0] got, input logic [64:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  initial begin
    a32 = '0; b32 = '0; c32 = 1'b0;
    a8 = '0; b8 = '0; c8 = 1'b0;
    a16 = '0; b16 = '0; c16 = 1'b0;
    a64 = '0; b64 = '0; c64 = 1'b0;
    #1;
    // R3 R8: idle inputs give a zero result with no clock edge needed
    checkRes("R3", {32'h0, co32, s32}, 65'h0);
    checkRes("R3", {56'h0, co8, s8}, 65'h0);

    // R1 R2 R3 R4 R8 R9: directed vector table on the 32-bit variable partition
    foreach (VECS[i]) begin
      a32 = VECS[i].a; b32 = VECS[i].b; c32 = VECS[i].ci;
      #1;
      checkRes("R1/R8 table", {32'h0, co32, s32}, {32'h0, VECS[i].co, VECS[i].s});
    end

    // R5 R6: exhaustive 8-bit, three stages so the final polarity is corrected
    for (int x = 0; x < 256; x++) begin
      for (int y = 0; y < 256; y++) begin
        for (int c = 0; c < 2; c++) begin
          a8 = x[7:0]; b8 = y[7:0]; c8 = c[0];
          #1;
          checkRes("R5 R6 exhaustive8", {56'h0, co8, s8},
                   {56'h0, 9'(x + y + c)});
        end
      end
    end

    // R6: 16-bit fixed partition with a 1-bit remainder stage
    for (int n = 0; n < 10000; n++) begin
      a16 = 16'($urandom); b16 = 16'($urandom); c16 = 1'($urandom);
      #1;
      checkRes("R6 random16", {48'h0, co16, s16},
               {48'h0, {1'b0, a16} + {1'b0, b16} + {16'h0, c16}});
    end

    // R7 R1: 32-bit and 64-bit variable partitions, random operands
    for (int n = 0; n < 10000; n++) begin
      a32 = $urandom; b32 = $urandom; c32 = 1'($urandom);
      a64 = {$urandom, $urandom}; b64 = {$urandom, $urandom}; c64 = 1'($urandom);
      #1;
      checkRes("R7 random32", {32'h0, co32, s32},
               {32'h0, {1'b0, a32} + {1'b0, b32} + {32'h0, c32}});
      checkRes("R7 random64", {co64, s64},
               {1'b0, a64} + {1'b0, b64} + {64'h0, c64});
    end

    // R2: all-propagate operands at each width, both carry values
    for (int c = 0; c < 2; c++) begin
      a16 = 16'h3C5A; b16 = ~16'h3C5A; c16 = c[0];
      a64 = 64'h0123456789ABCDEF; b64 = ~64'h0123456789ABCDEF; c64 = c[0];
      a8 = 8'hA5; b8 = 8'h5A; c8 = c[0];
      #1;
      checkRes("R2 prop16", {48'h0, co16, s16}, {48'h0, c[0], c[0] ? 16'h0 : 16'hFFFF});
      checkRes("R2 prop64", {co64, s64}, {c[0], c[0] ? 64'h0 : 64'hFFFFFFFFFFFFFFFF});
      checkRes("R2 prop8", {56'h0, co8, s8}, {56'h0, c[0], c[0] ? 8'h0 : 8'hFF});
    end

    // R4: full ripple across every boundary at 16 and 64 bits
    a16 = 16'hFFFF; b16 = '0; c16 = 1'b1;
    a64 = '1; b64 = '0; c64 = 1'b1;
    #1;
    checkRes("R4 ripple16", {48'h0, co16, s16}, {48'h0, 17'h10000});
    checkRes("R4 ripple64", {co64, s64}, {1'b1, 64'h0});

    // R9: wrap gives a smaller sum
    a64 = 64'hF000000000000000; b64 = 64'h2000000000000001; c64 = 1'b0;
    #1;
    checkRes("R9 wrap64", {co64, s64}, {1'b1, 64'h1000000000000001});

    finishRun();
  end
endmodule